// File: doc/BRIEF.md
# Vector Carry-Family Instruction Decoder

This block sits in the decode stage of a vector unit. It examines 32-bit instruction words and recognises the integer add-with-carry and subtract-with-borrow group. That group has four operations. Two write a full-width sum or difference (add-carry and sub-borrow). Two write only the carry-out or borrow-out bit into a single mask register (mask-add-carry and mask-sub-borrow). Each operation takes its second operand from one of three places: another vector register group, a scalar register index, or a small signed immediate.

For every qualified word, the block checks whether the encoding belongs to the group and whether the vector unit is switched on. It also checks whether the register indices are legal under the current register-grouping exponent (group size 2^L registers). One cycle later it reports either a clean decode (operation, operand form, register indices and sign-extended immediate) or a raised illegal flag with every other field forced to zero. Execution of the arithmetic is left to downstream logic.

Top module: `vcarry_decode`

## Requirements
- R1: A word presented with `insn_vld` high at a rising clock edge produces its result, with `dec_vld` high, right after that edge. A cycle with `insn_vld` low produces `dec_vld` and `dec_illegal` low and all fields zero after the edge. Synchronous reset clears every output to zero.
- R2: A word belongs to the group only if bits[6:0] equal 1010111, bit 25 is 1, and bits[31:26] are 010000 (add-carry, `dec_op`=0), 010001 (mask-add-carry, 1), 010010 (sub-borrow, 2) or 010011 (mask-sub-borrow, 3). Any other word is illegal.
- R3: Bits[14:12] select the form: 000 is vector-vector (`dec_form`=1), 100 is vector-scalar (2), and 011 is immediate (3). Any other value is illegal. The immediate form is illegal for sub-borrow and mask-sub-borrow.
- R4: A word presented while `vec_en` is low is illegal even if its encoding is valid.
- R5: With group size G=2^`lmul_exp`, the vs2 index (bits[24:20]) must be a multiple of G. In the vector-vector form the vs1 index (bits[19:15]) must also be a multiple of G. For add-carry and sub-borrow the destination (bits[11:7]) must be a multiple of G. Bits[19:15] are not checked in the scalar and immediate forms.
- R6: Add-carry and sub-borrow with destination register 0 are illegal when `lmul_exp` is non-zero and legal when it is zero.
- R7: Mask-add-carry and mask-sub-borrow are illegal when the destination index lies in [vs2, vs2+G-1], or, in the vector-vector form, in [vs1, vs1+G-1]. Their destination need not be a multiple of G.
- R8: A legal decode reports `dec_vd`, `dec_vs2`, and `dec_src1` (bits[19:15] in vector-vector and vector-scalar forms, zero in immediate form). It also reports `dec_imm`: bits[19:15] sign-extended to IMM_W in immediate form, zero otherwise.
- R9: An illegal decode raises `dec_illegal` and drives `dec_op`, `dec_form`, `dec_vd`, `dec_vs2`, `dec_src1` and `dec_imm` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_vld | input | 1 | Qualifies `insn` this cycle |
| insn | input | 32 | Instruction word |
| vec_en | input | 1 | Vector unit enabled |
| lmul_exp | input | 2 | Register-grouping exponent L (group of 2^L) |
| dec_vld | output | 1 | A result is present |
| dec_illegal | output | 1 | Word rejected |
| dec_op | output | 2 | 0 add-carry, 1 mask-add-carry, 2 sub-borrow, 3 mask-sub-borrow |
| dec_form | output | 2 | 0 none, 1 vector-vector, 2 vector-scalar, 3 immediate |
| dec_vd | output | 5 | Destination index |
| dec_vs2 | output | 5 | First source group index |
| dec_src1 | output | 5 | Second source index (vector or scalar) |
| dec_imm | output | IMM_W | Sign-extended immediate |

## Verification
Every result is due exactly one clock edge after the word is qualified: there is one register stage and nothing else lies between input and output. Each scenario drives its inputs on a falling edge and waits for the next rising edge. It then samples one nanosecond later, so the value read is the registered decode of that word alone. The idle case and the reset case are sampled the same way to confirm that fields fall to zero on that same edge.

// File: rtl/vcd_pkg.sv
package vcd_pkg;

    localparam int INSN_W = 32;
    localparam int REG_W  = 5;
    localparam int LMUL_W = 2;

    localparam logic [6:0] VEC_MAJOR = 7'b1010111;

    localparam logic [5:0] F6_ADC  = 6'b010000;
    localparam logic [5:0] F6_MADC = 6'b010001;
    localparam logic [5:0] F6_SBC  = 6'b010010;
    localparam logic [5:0] F6_MSBC = 6'b010011;

    localparam logic [2:0] F3_VV = 3'b000;
    localparam logic [2:0] F3_VX = 3'b100;
    localparam logic [2:0] F3_VI = 3'b011;

    typedef enum logic [1:0] {
        OP_ADC  = 2'd0,
        OP_MADC = 2'd1,
        OP_SBC  = 2'd2,
        OP_MSBC = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        FORM_NONE = 2'd0,
        FORM_VV   = 2'd1,
        FORM_VX   = 2'd2,
        FORM_VI   = 2'd3
    } form_e;

    // Bit layout of a 32-bit word, most significant field first.
    typedef struct packed {
        logic [5:0]       funct6;
        logic             vm;
        logic [REG_W-1:0] rs2;
        logic [REG_W-1:0] rs1;
        logic [2:0]       funct3;
        logic [REG_W-1:0] rd;
        logic [6:0]       opcode;
    } insn_t;

    // Index is usable as the base of a 2^lmul register group.
    function automatic logic grp_aligned(input logic [REG_W-1:0]  idx,
                                         input logic [LMUL_W-1:0] lmul);
        logic [REG_W-1:0] msk;
        msk = (REG_W'(1) << lmul) - REG_W'(1);
        return (idx & msk) == '0;
    endfunction

    // Register reg_i falls inside the group starting at base.
    function automatic logic in_group(input logic [REG_W-1:0]  reg_i,
                                      input logic [REG_W-1:0]  base,
                                      input logic [LMUL_W-1:0] lmul);
        logic [REG_W:0] lo;
        logic [REG_W:0] hi;
        lo = {1'b0, base};
        hi = lo + ((REG_W+1)'(1) << lmul);
        return ({1'b0, reg_i} >= lo) && ({1'b0, reg_i} < hi);
    endfunction

endpackage

// File: rtl/vcd_classify.sv
module vcd_classify
    import vcd_pkg::*;
(
    input  insn_t f,
    output logic  known,
    output op_e   op,
    output form_e form
);
    logic op_hit;
    logic imm_ok;

    always_comb begin
        op     = OP_ADC;
        op_hit = 1'b1;
        case (f.funct6)
            F6_ADC:  op = OP_ADC;
            F6_MADC: op = OP_MADC;
            F6_SBC:  op = OP_SBC;
            F6_MSBC: op = OP_MSBC;
            default: op_hit = 1'b0;
        endcase
    end

    always_comb begin
        case (f.funct3)
            F3_VV:   form = FORM_VV;
            F3_VX:   form = FORM_VX;
            F3_VI:   form = FORM_VI;
            default: form = FORM_NONE;
        endcase
    end

    // Immediate operand exists only for the two addition operations.
    assign imm_ok = (form != FORM_VI) || (op == OP_ADC) || (op == OP_MADC);

    assign known = (f.opcode == VEC_MAJOR) && f.vm && op_hit &&
                   (form != FORM_NONE) && imm_ok;

endmodule

// File: rtl/vcd_legal.sv
module vcd_legal
    import vcd_pkg::*;
(
    input  op_e               op,
    input  form_e             form,
    input  logic [REG_W-1:0]  rd,
    input  logic [REG_W-1:0]  rs2,
    input  logic [REG_W-1:0]  rs1,
    input  logic [LMUL_W-1:0] lmul,
    output logic              regs_ok
);
    localparam int NSRC = 2;   // slot 0: vs2, slot 1: vs1

    logic             is_mask;
    logic             dst_bad;
    logic [REG_W-1:0] src_idx  [NSRC];
    logic [NSRC-1:0]  src_used;
    logic [NSRC-1:0]  src_bad;

    assign is_mask = (op == OP_MADC) || (op == OP_MSBC);

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        if (i == 0) begin : g_vs2
            assign src_idx[i]  = rs2;
            assign src_used[i] = 1'b1;
        end else begin : g_vs1
            assign src_idx[i]  = rs1;
            assign src_used[i] = (form == FORM_VV);
        end
        assign src_bad[i] = src_used[i] &&
                            (!grp_aligned(src_idx[i], lmul) ||
                             (is_mask && in_group(rd, src_idx[i], lmul)));
    end

    // Full-width results need an aligned group, and register 0 only ungrouped.
    assign dst_bad = !is_mask &&
                     (!grp_aligned(rd, lmul) || ((rd == '0) && (lmul != '0)));

    assign regs_ok = !dst_bad && (src_bad == '0);

endmodule

// File: rtl/vcarry_decode.sv
module vcarry_decode
    import vcd_pkg::*;
#(
    parameter int IMM_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                insn_vld,
    input  logic [INSN_W-1:0]   insn,
    input  logic                vec_en,
    input  logic [LMUL_W-1:0]   lmul_exp,
    output logic                dec_vld,
    output logic                dec_illegal,
    output logic [1:0]          dec_op,
    output logic [1:0]          dec_form,
    output logic [REG_W-1:0]    dec_vd,
    output logic [REG_W-1:0]    dec_vs2,
    output logic [REG_W-1:0]    dec_src1,
    output logic [IMM_W-1:0]    dec_imm
);
    localparam int EXT_W = IMM_W - REG_W;

    insn_t            f;
    logic             known;
    op_e              op;
    form_e            form;
    logic             regs_ok;
    logic             accept;
    logic [REG_W-1:0] src1_n;
    logic [IMM_W-1:0] imm_n;

    assign f = insn_t'(insn);

    vcd_classify u_classify (
        .f     (f),
        .known (known),
        .op    (op),
        .form  (form)
    );

    vcd_legal u_legal (
        .op      (op),
        .form    (form),
        .rd      (f.rd),
        .rs2     (f.rs2),
        .rs1     (f.rs1),
        .lmul    (lmul_exp),
        .regs_ok (regs_ok)
    );

    assign accept = known && vec_en && regs_ok;
    assign src1_n = (form == FORM_VI) ? '0 : f.rs1;
    assign imm_n  = (form == FORM_VI) ? {{EXT_W{f.rs1[REG_W-1]}}, f.rs1} : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_vld     <= 1'b0;
            dec_illegal <= 1'b0;
            dec_op      <= '0;
            dec_form    <= '0;
            dec_vd      <= '0;
            dec_vs2     <= '0;
            dec_src1    <= '0;
            dec_imm     <= '0;
        end else begin
            dec_vld     <= insn_vld;
            dec_illegal <= insn_vld && !accept;
            if (insn_vld && accept) begin
                dec_op   <= op;
                dec_form <= form;
                dec_vd   <= f.rd;
                dec_vs2  <= f.rs2;
                dec_src1 <= src1_n;
                dec_imm  <= imm_n;
            end else begin
                dec_op   <= '0;
                dec_form <= '0;
                dec_vd   <= '0;
                dec_vs2  <= '0;
                dec_src1 <= '0;
                dec_imm  <= '0;
            end
        end
    end

    // R1: result strobe follows the qualifier by one edge
    p_vld_follow_r1: assert property (@(posedge clk) disable iff (rst)
        insn_vld |=> dec_vld);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !insn_vld |=> (!dec_vld && !dec_illegal));

    // R4: a disabled unit never yields a decode
    p_disabled_r4: assert property (@(posedge clk) disable iff (rst)
        (insn_vld && !vec_en) |=> dec_illegal);

    // R3: immediate form only pairs with the addition operations
    p_imm_pair_r3: assert property (@(posedge clk) disable iff (rst)
        (dec_form == FORM_VI) |-> (dec_op == OP_ADC || dec_op == OP_MADC));

    // R6: full-width result into register 0 only when ungrouped
    p_no_v0_r6: assert property (@(posedge clk) disable iff (rst)
        (dec_vld && !dec_illegal && !dec_op[0] && dec_vd == '0)
            |-> ($past(lmul_exp) == '0));

    // R7: accepted mask result stays clear of the vs2 group
    p_mask_apart_r7: assert property (@(posedge clk) disable iff (rst)
        (dec_vld && !dec_illegal && dec_op[0])
            |-> !in_group(dec_vd, dec_vs2, $past(lmul_exp)));

    // R8: immediate field is zero outside the immediate form
    p_imm_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (dec_form != FORM_VI) |-> (dec_imm == '0));

    // R9: a rejected word leaves every field at zero
    p_quiet_fields_r9: assert property (@(posedge clk) disable iff (rst)
        dec_illegal |-> (dec_op == '0 && dec_form == '0 && dec_vd == '0 &&
                         dec_vs2 == '0 && dec_src1 == '0 && dec_imm == '0));

endmodule

// File: tb/tb_vcarry_decode.sv
module tb_vcarry_decode;
    import vcd_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        insn_vld;
    logic [31:0] insn;
    logic        vec_en;
    logic [1:0]  lmul_exp;
    logic        dec_vld;
    logic        dec_illegal;
    logic [1:0]  dec_op;
    logic [1:0]  dec_form;
    logic [4:0]  dec_vd;
    logic [4:0]  dec_vs2;
    logic [4:0]  dec_src1;
    logic [31:0] dec_imm;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    vcarry_decode #(.IMM_W(32)) dut (
        .clk(clk), .rst(rst), .insn_vld(insn_vld), .insn(insn),
        .vec_en(vec_en), .lmul_exp(lmul_exp), .dec_vld(dec_vld),
        .dec_illegal(dec_illegal), .dec_op(dec_op), .dec_form(dec_form),
        .dec_vd(dec_vd), .dec_vs2(dec_vs2), .dec_src1(dec_src1),
        .dec_imm(dec_imm)
    );

    function automatic logic [31:0] enc(input logic [5:0] f6, input logic vm,
                                        input logic [4:0] rs2, input logic [4:0] rs1,
                                        input logic [2:0] f3, input logic [4:0] rd);
        return {f6, vm, rs2, rs1, f3, rd, 7'b1010111};
    endfunction

    task automatic cmp(input string rq, input string nm,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, nm, got, exp);
        end
    endtask

    // Present one word, then sample one nanosecond after the capturing edge.
    task automatic run_case(input string rq, input logic [31:0] w,
                            input logic en, input logic [1:0] lm,
                            input logic ill, input logic [1:0] op,
                            input logic [1:0] fm, input logic [4:0] vd,
                            input logic [4:0] vs2, input logic [4:0] s1,
                            input logic [31:0] imm);
        @(negedge clk);
        insn_vld = 1'b1; insn = w; vec_en = en; lmul_exp = lm;
        @(posedge clk); #1;
        cmp(rq, "vld",     {31'd0, dec_vld},     32'd1);
        cmp(rq, "illegal", {31'd0, dec_illegal}, {31'd0, ill});
        cmp(rq, "op",      {30'd0, dec_op},      {30'd0, op});
        cmp(rq, "form",    {30'd0, dec_form},    {30'd0, fm});
        cmp(rq, "vd",      {27'd0, dec_vd},      {27'd0, vd});
        cmp(rq, "vs2",     {27'd0, dec_vs2},     {27'd0, vs2});
        cmp(rq, "src1",    {27'd0, dec_src1},    {27'd0, s1});
        cmp(rq, "imm",     dec_imm,              imm);
    endtask

    task automatic expect_illegal(input string rq, input logic [31:0] w,
                                  input logic en, input logic [1:0] lm);
        run_case(rq, w, en, lm, 1'b1, 2'd0, 2'd0, 5'd0, 5'd0, 5'd0, 32'd0);
    endtask

    task automatic t_reset;
        rst = 1'b1; insn_vld = 1'b1; insn = enc(6'b010000, 1'b1, 5'd4, 5'd8, 3'b000, 5'd12);
        vec_en = 1'b1; lmul_exp = 2'd0;
        repeat (3) @(posedge clk);
        #1;
        cmp("R1", "reset vld", {31'd0, dec_vld}, 32'd0);
        cmp("R1", "reset illegal", {31'd0, dec_illegal}, 32'd0);
        cmp("R1", "reset vd", {27'd0, dec_vd}, 32'd0);
        @(negedge clk); rst = 1'b0; insn_vld = 1'b0;
    endtask

    task automatic t_add_vv;   // R2 R3 R5 R8
        run_case("R2", enc(6'b010000, 1'b1, 5'd4, 5'd8, 3'b000, 5'd12), 1'b1, 2'd2,
                 1'b0, 2'd0, 2'd1, 5'd12, 5'd4, 5'd8, 32'd0);
    endtask

    task automatic t_madc_vx;  // R7 R8: scalar index unaligned is fine
        run_case("R8", enc(6'b010001, 1'b1, 5'd6, 5'd3, 3'b100, 5'd9), 1'b1, 2'd1,
                 1'b0, 2'd1, 2'd2, 5'd9, 5'd6, 5'd3, 32'd0);
        run_case("R7", enc(6'b010001, 1'b1, 5'd2, 5'd4, 3'b000, 5'd7), 1'b1, 2'd1,
                 1'b0, 2'd1, 2'd1, 5'd7, 5'd2, 5'd4, 32'd0);
    endtask

    task automatic t_imm;      // R8 R3
        run_case("R8", enc(6'b010001, 1'b1, 5'd2, 5'b10110, 3'b011, 5'd5), 1'b1, 2'd0,
                 1'b0, 2'd1, 2'd3, 5'd5, 5'd2, 5'd0, 32'hFFFF_FFF6);
        run_case("R8", enc(6'b010000, 1'b1, 5'd4, 5'd7, 3'b011, 5'd8), 1'b1, 2'd2,
                 1'b0, 2'd0, 2'd3, 5'd8, 5'd4, 5'd0, 32'd7);
        expect_illegal("R3", enc(6'b010010, 1'b1, 5'd2, 5'd1, 3'b011, 5'd4), 1'b1, 2'd0);
        expect_illegal("R3", enc(6'b010011, 1'b1, 5'd2, 5'd1, 3'b011, 5'd9), 1'b1, 2'd0);
    endtask

    task automatic t_overlap;  // R7
        expect_illegal("R7", enc(6'b010011, 1'b1, 5'd8, 5'd16, 3'b000, 5'd15), 1'b1, 2'd3);
        expect_illegal("R7", enc(6'b010011, 1'b1, 5'd8, 5'd16, 3'b000, 5'd16), 1'b1, 2'd3);
        run_case("R7", enc(6'b010011, 1'b1, 5'd8, 5'd16, 3'b000, 5'd24), 1'b1, 2'd3,
                 1'b0, 2'd3, 2'd1, 5'd24, 5'd8, 5'd16, 32'd0);
        expect_illegal("R7", enc(6'b010001, 1'b1, 5'd5, 5'd5, 3'b100, 5'd5), 1'b1, 2'd0);
        run_case("R7", enc(6'b010011, 1'b1, 5'd4, 5'd6, 3'b100, 5'd6), 1'b1, 2'd1,
                 1'b0, 2'd3, 2'd2, 5'd6, 5'd4, 5'd6, 32'd0);
    endtask

    task automatic t_v0;       // R6
        expect_illegal("R6", enc(6'b010000, 1'b1, 5'd2, 5'd4, 3'b000, 5'd0), 1'b1, 2'd1);
        expect_illegal("R6", enc(6'b010010, 1'b1, 5'd8, 5'd1, 3'b100, 5'd0), 1'b1, 2'd3);
        run_case("R6", enc(6'b010010, 1'b1, 5'd3, 5'd1, 3'b100, 5'd0), 1'b1, 2'd0,
                 1'b0, 2'd2, 2'd2, 5'd0, 5'd3, 5'd1, 32'd0);
    endtask

    task automatic t_align;    // R5
        expect_illegal("R5", enc(6'b010000, 1'b1, 5'd4, 5'd8, 3'b000, 5'd2), 1'b1, 2'd2);
        expect_illegal("R5", enc(6'b010010, 1'b1, 5'd4, 5'd3, 3'b000, 5'd8), 1'b1, 2'd2);
        expect_illegal("R5", enc(6'b010001, 1'b1, 5'd6, 5'd1, 3'b100, 5'd0), 1'b1, 2'd2);
        run_case("R5", enc(6'b010010, 1'b1, 5'd8, 5'd3, 3'b100, 5'd4), 1'b1, 2'd2,
                 1'b0, 2'd2, 2'd2, 5'd4, 5'd8, 5'd3, 32'd0);
    endtask

    task automatic t_disabled; // R4
        expect_illegal("R4", enc(6'b010000, 1'b1, 5'd4, 5'd8, 3'b000, 5'd12), 1'b0, 2'd2);
    endtask

    task automatic t_foreign;  // R2 R3
        expect_illegal("R2", enc(6'b010000, 1'b0, 5'd4, 5'd8, 3'b000, 5'd12), 1'b1, 2'd0);
        expect_illegal("R2", {enc(6'b010000, 1'b1, 5'd4, 5'd8, 3'b000, 5'd12)} ^ 32'd1,
                       1'b1, 2'd0);
        expect_illegal("R2", enc(6'b010100, 1'b1, 5'd4, 5'd8, 3'b000, 5'd12), 1'b1, 2'd0);
        expect_illegal("R3", enc(6'b010000, 1'b1, 5'd4, 5'd8, 3'b001, 5'd12), 1'b1, 2'd0);
    endtask

    task automatic t_idle;     // R1
        @(negedge clk);
        insn_vld = 1'b0; insn = enc(6'b010000, 1'b1, 5'd4, 5'd8, 3'b000, 5'd12);
        vec_en = 1'b1; lmul_exp = 2'd0;
        @(posedge clk); #1;
        cmp("R1", "idle vld", {31'd0, dec_vld}, 32'd0);
        cmp("R1", "idle illegal", {31'd0, dec_illegal}, 32'd0);
        cmp("R1", "idle vd", {27'd0, dec_vd}, 32'd0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_add_vv();
        t_madc_vx();
        t_imm();
        t_overlap();
        t_v0();
        t_align();
        t_disabled();
        t_foreign();
        t_idle();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule